// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block links two processor-side register ports, called side A and side B, through a pair of one-way queues. Words that side A writes can only be read by side B. Words that side B writes can only be read by side A. Each side sees only its own transmit queue and its own receive queue. The two queues are 32 bits wide and 8 entries deep by default.

Each side uses three word addresses on its port:

- Address 0: transmit data. A write pushes a word into this side's transmit queue.
- Address 1: receive data. A read returns the oldest word of this side's receive queue and pops it in the same access.
- Address 2: status.

A push into a full queue is dropped. A pop from an empty queue is dropped and returns zero. Each of these events sets a sticky error flag for the side that caused it, and any write to that side's status address clears both of its flags.

Each side has a level interrupt. It is high while the side has data waiting to be read or while either of its error flags is set. Software on each processor can therefore sleep until the other side sends a message or until a protocol error occurs.

Top module: `dual_mailbox`

## Requirements
- R1: Words pushed through one side's transmit-data address (address 0) are returned in the same order by the other side's receive-data address (address 1). Each read returns the oldest entry and removes it. A queue holds DEPTH (8) entries.
- R2: A word written by side A is visible only to side B, and a word written by side B is visible only to side A. A side's own receive status does not change when it writes.
- R3: Status (address 2) bit 0 is 1 exactly when this side's receive queue holds at least one entry.
- R4: Status bit 1 is 1 exactly when this side's transmit queue is not full.
- R5: A transmit write while the transmit queue is full is discarded and sets sticky status bit 2 of the writing side.
- R6: A receive read while the receive queue is empty returns zero, removes nothing, and sets sticky status bit 3 of the reading side.
- R7: Any write to the status address clears bits 2 and 3 of the writing side only. It does not change bit 0 or any queue content.
- R8: Each side's interrupt equals status bit 0 OR bit 2 OR bit 3 of that side, as a level.
- R9: A push and a pop on the same non-empty, non-full queue in the same cycle leave its occupancy unchanged, and both take effect.
- R10: Reset empties both queues and clears all flags, so each side's status reads 2 and both interrupts are low.
- R11: Status bits 31 to 4 read as zero. A read of address 3, and any cycle without a read strobe, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 2 | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data, valid in the strobe cycle |
| a_irq | output | 1 | Side A interrupt level |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 2 | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data, valid in the strobe cycle |
| b_irq | output | 1 | Side B interrupt level |

## Verification
The assertions check the following on every cycle:
- Queue occupancy never exceeds the depth.
- A side with pending receive data always has its interrupt raised.
- An empty-queue read returns zero and raises the interrupt one cycle later.
- A full-queue write raises the writer's interrupt.
- A status write leaves the interrupt equal to the receive-not-empty level alone.
- A simultaneous push and pop keep the count stable.
- The upper status bits stay zero.

Word ordering, direction isolation and the exact status values under mixed traffic on both sides are shown only by the bench's reference queues across its directed and pseudo-random scenarios.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic [1:0] ADR_TXD = 2'd0;
   localparam logic [1:0] ADR_RXD = 2'd1;
   localparam logic [1:0] ADR_STS = 2'd2;

   localparam int STB_RX_AVAIL = 0;
   localparam int STB_TX_ROOM  = 1;
   localparam int STB_OVERRUN  = 2;
   localparam int STB_UNDERRUN = 3;
   localparam int STS_USED     = 4;

   typedef struct packed {
      logic underrun;
      logic overrun;
   } mbx_err_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int W = 32,
   parameter int D = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_req,
   input  logic [W-1:0]               push_data,
   input  logic                       pop_req,
   output logic [W-1:0]               head,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(D+1)-1:0]     count
);
   localparam int AW   = (D > 1) ? $clog2(D) : 1;
   localparam int CW   = $clog2(D + 1);
   localparam bit POW2 = (D & (D - 1)) == 0;

   if (D < 2) begin : g_bad_depth
      $error("mbx_fifo: depth must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mbx_fifo: width must be at least 1");
   end

   logic [W-1:0]  mem [D];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(D));
   assign empty   = (cnt == '0);
   assign do_push = push_req && !full;
   assign do_pop  = pop_req && !empty;
   assign head    = mem[rptr];
   assign count   = cnt;

   if (POW2) begin : g_wrap_nat
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(D - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(D - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
   import mbx_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         rd,
   input  logic [1:0]   addr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] rx_head,
   input  logic         rx_empty,
   input  logic         tx_full,
   output logic         tx_push,
   output logic [W-1:0] tx_data,
   output logic         rx_pop,
   output logic [W-1:0] rdata,
   output logic         irq
);
   if (W < STS_USED) begin : g_bad_width
      $error("mbx_port: data width too small for status");
   end

   mbx_err_t     err;
   logic         sts_wr;
   logic [W-1:0] status;

   assign tx_push = wr && (addr == ADR_TXD);
   assign tx_data = wdata;
   assign rx_pop  = rd && (addr == ADR_RXD);
   assign sts_wr  = wr && (addr == ADR_STS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= '0;
      end else if (sts_wr) begin
         err <= '0;
      end else begin
         if (tx_push && tx_full)  err.overrun  <= 1'b1;
         if (rx_pop && rx_empty)  err.underrun <= 1'b1;
      end
   end

   always_comb begin
      status               = '0;
      status[STB_RX_AVAIL] = !rx_empty;
      status[STB_TX_ROOM]  = !tx_full;
      status[STB_OVERRUN]  = err.overrun;
      status[STB_UNDERRUN] = err.underrun;
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            ADR_RXD: rdata = rx_empty ? '0 : rx_head;
            ADR_STS: rdata = status;
            default: rdata = '0;
         endcase
      end
   end

   assign irq = !rx_empty || err.overrun || err.underrun;
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr,
   input  logic              a_rd,
   input  logic [1:0]        a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq,
   input  logic              b_wr,
   input  logic              b_rd,
   input  logic [1:0]        b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq
);
   localparam int CW = $clog2(DEPTH + 1);

   logic              s_wr    [2];
   logic              s_rd    [2];
   logic [1:0]        s_addr  [2];
   logic [DATA_W-1:0] s_wdata [2];
   logic [DATA_W-1:0] s_rdata [2];
   logic              s_irq   [2];

   logic              q_push  [2];
   logic [DATA_W-1:0] q_pdata [2];
   logic              q_pop   [2];
   logic [DATA_W-1:0] q_head  [2];
   logic              q_full  [2];
   logic              q_empty [2];
   logic [CW-1:0]     fifo_cnt[2];

   assign s_wr[0]    = a_wr;
   assign s_rd[0]    = a_rd;
   assign s_addr[0]  = a_addr;
   assign s_wdata[0] = a_wdata;
   assign s_wr[1]    = b_wr;
   assign s_rd[1]    = b_rd;
   assign s_addr[1]  = b_addr;
   assign s_wdata[1] = b_wdata;
   assign a_rdata    = s_rdata[0];
   assign a_irq      = s_irq[0];
   assign b_rdata    = s_rdata[1];
   assign b_irq      = s_irq[1];

   // Queue g is written by side g and read by the other side.
   for (genvar g = 0; g < 2; g++) begin : g_side
      localparam int PEER = 1 - g;

      mbx_fifo #(.W(DATA_W), .D(DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push_req (q_push[g]),
         .push_data(q_pdata[g]),
         .pop_req  (q_pop[PEER]),
         .head     (q_head[g]),
         .full     (q_full[g]),
         .empty    (q_empty[g]),
         .count    (fifo_cnt[g])
      );

      mbx_port #(.W(DATA_W)) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (s_wr[g]),
         .rd      (s_rd[g]),
         .addr    (s_addr[g]),
         .wdata   (s_wdata[g]),
         .rx_head (q_head[PEER]),
         .rx_empty(q_empty[PEER]),
         .tx_full (q_full[g]),
         .tx_push (q_push[g]),
         .tx_data (q_pdata[g]),
         .rx_pop  (q_pop[g]),
         .rdata   (s_rdata[g]),
         .irq     (s_irq[g])
      );
   end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_wr,
   input logic              a_rd,
   input logic [1:0]        a_addr,
   input logic [DATA_W-1:0] a_rdata,
   input logic              a_irq,
   input logic              b_wr,
   input logic              b_rd,
   input logic [1:0]        b_addr,
   input logic [DATA_W-1:0] b_rdata,
   input logic              b_irq,
   input logic [CW-1:0]     cnt_ab,
   input logic [CW-1:0]     cnt_ba
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ab <= CW'(DEPTH)) && (cnt_ba <= CW'(DEPTH))); // R1
   AST_RX_DATA_IRQ_A: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ba != '0) |-> a_irq); // R8
   AST_RX_DATA_IRQ_B: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ab != '0) |-> b_irq); // R8
   AST_FULL_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == ADR_TXD && cnt_ab == CW'(DEPTH)) |=> a_irq); // R5
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd && b_addr == ADR_RXD && cnt_ab == '0) |-> (b_rdata == '0)); // R6
   AST_EMPTY_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && a_addr == ADR_RXD && cnt_ba == '0) |=> a_irq); // R6
   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == ADR_STS) |=> (a_irq == (cnt_ba != '0))); // R7
   AST_PUSH_POP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_addr == ADR_TXD && b_rd && b_addr == ADR_RXD &&
       cnt_ab != '0 && cnt_ab != CW'(DEPTH)) |=> $stable(cnt_ab)); // R9
   AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && a_addr == ADR_STS) |-> (a_rdata[DATA_W-1:STS_USED] == '0)); // R11
endmodule

bind dual_mailbox mbx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .a_wr   (a_wr),
   .a_rd   (a_rd),
   .a_addr (a_addr),
   .a_rdata(a_rdata),
   .a_irq  (a_irq),
   .b_wr   (b_wr),
   .b_rd   (b_rd),
   .b_addr (b_addr),
   .b_rdata(b_rdata),
   .b_irq  (b_irq),
   .cnt_ab (fifo_cnt[0]),
   .cnt_ba (fifo_cnt[1])
);

// File: tb/tb_dual_mailbox.sv
module tb_dual_mailbox;
   localparam int DW = 32;
   localparam int DP = 8;
   // operation codes used by the bench only
   localparam int OP_IDLE = 0, OP_TX = 1, OP_RX = 2, OP_RST = 3, OP_WST = 4, OP_R3 = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
   logic [1:0]    a_addr = 0, b_addr = 0;
   logic [DW-1:0] a_wdata = 0, b_wdata = 0;
   logic [DW-1:0] a_rdata, b_rdata;
   logic          a_irq, b_irq;

   dual_mailbox #(.DATA_W(DW), .DEPTH(DP)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_irq(a_irq),
      .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_irq(b_irq)
   );

   always #2 clk = ~clk;

   // reference model
   logic [DW-1:0] q0 [$]; // A -> B
   logic [DW-1:0] q1 [$]; // B -> A
   bit ovf [2];
   bit unf [2];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int rx_size(int s);
      return (s == 0) ? q1.size() : q0.size();
   endfunction

   function automatic int tx_size(int s);
      return (s == 0) ? q0.size() : q1.size();
   endfunction

   function automatic logic [DW-1:0] exp_rd(int s, int op);
      logic [DW-1:0] v = '0;
      if (op == OP_RX) begin
         if (rx_size(s) > 0) v = (s == 0) ? q1[0] : q0[0];
      end else if (op == OP_RST) begin
         v[0] = rx_size(s) > 0;
         v[1] = tx_size(s) < DP;
         v[2] = ovf[s];
         v[3] = unf[s];
      end
      return v;
   endfunction

   task automatic drive(int s, int op, logic [DW-1:0] d);
      logic w, r;
      logic [1:0] ad;
      w = (op == OP_TX) || (op == OP_WST);
      r = (op == OP_RX) || (op == OP_RST) || (op == OP_R3);
      case (op)
         OP_TX:          ad = 2'd0;
         OP_RX:          ad = 2'd1;
         OP_RST, OP_WST: ad = 2'd2;
         OP_R3:          ad = 2'd3;
         default:        ad = 2'd0;
      endcase
      if (s == 0) begin a_wr = w; a_rd = r; a_addr = ad; a_wdata = d; end
      else        begin b_wr = w; b_rd = r; b_addr = ad; b_wdata = d; end
   endtask

   task automatic step(int oa, logic [DW-1:0] da, int ob, logic [DW-1:0] db, string req);
      int n0, n1;
      @(negedge clk);
      drive(0, oa, da);
      drive(1, ob, db);
      #1;
      check(req, a_rdata, exp_rd(0, oa));
      check(req, b_rdata, exp_rd(1, ob));
      @(posedge clk);
      #1;
      n0 = q0.size();
      n1 = q1.size();
      // side A
      if (oa == OP_TX) begin if (n0 < DP) q0.push_back(da); else ovf[0] = 1; end
      if (oa == OP_RX) begin if (n1 > 0) void'(q1.pop_front()); else unf[0] = 1; end
      if (oa == OP_WST) begin ovf[0] = 0; unf[0] = 0; end
      // side B
      if (ob == OP_TX) begin if (n1 < DP) q1.push_back(db); else ovf[1] = 1; end
      if (ob == OP_RX) begin if (n0 > 0) void'(q0.pop_front()); else unf[1] = 1; end
      if (ob == OP_WST) begin ovf[1] = 0; unf[1] = 0; end
   endtask

   // interrupt levels compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R8 irq_a", {31'b0, a_irq}, {31'b0, (q1.size() > 0) || ovf[0] || unf[0]});
         check("R8 irq_b", {31'b0, b_irq}, {31'b0, (q0.size() > 0) || ovf[1] || unf[1]});
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      drive(0, OP_IDLE, 0);
      drive(1, OP_IDLE, 0);
      q0.delete(); q1.delete();
      ovf = '{0, 0}; unf = '{0, 0};
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R10: reset state
      step(OP_RST, 0, OP_RST, 0, "R10 reset status");
      check("R10 irq_a", {31'b0, a_irq}, 32'd0);
      check("R10 irq_b", {31'b0, b_irq}, 32'd0);
      // R11: unused address and upper bits
      step(OP_R3, 0, OP_R3, 0, "R11 addr3 zero");
      // R1/R2: ordering and direction
      for (int i = 0; i < 3; i++) step(OP_TX, 32'hA000_0000 + i, OP_IDLE, 0, "R1 push");
      step(OP_RST, 0, OP_RST, 0, "R2 R3 status after A writes");
      for (int i = 0; i < 3; i++) step(OP_IDLE, 0, OP_RX, 0, "R1 order");
      step(OP_TX, 32'h1111_2222, OP_TX, 32'h3333_4444, "R2 cross writes");
      step(OP_RX, 0, OP_RX, 0, "R2 cross reads");
      // R4/R5: fill and overflow
      for (int i = 0; i < DP; i++) step(OP_TX, 32'hC0DE_0000 + i, OP_IDLE, 0, "R1 fill");
      step(OP_RST, 0, OP_RST, 0, "R4 full status");
      step(OP_TX, 32'hDEAD_BEEF, OP_IDLE, 0, "R5 overflow write");
      step(OP_RST, 0, OP_IDLE, 0, "R5 overflow flag");
      // R9: push and pop while full: push dropped
      step(OP_TX, 32'hBAD0_0001, OP_RX, 0, "R9 full push with pop");
      // R7: clear on status write by A only
      step(OP_WST, 32'hFFFF_FFFF, OP_RST, 0, "R7 clear A");
      step(OP_RST, 0, OP_IDLE, 0, "R7 A cleared");
      // R9: simultaneous in the middle
      step(OP_TX, 32'h5555_0001, OP_RX, 0, "R9 push pop mid");
      step(OP_IDLE, 0, OP_RST, 0, "R9 count kept");
      // R6: drain B and underflow
      for (int i = 0; i < DP; i++) step(OP_IDLE, 0, OP_RX, 0, "R1 drain");
      step(OP_IDLE, 0, OP_RX, 0, "R6 empty read");
      step(OP_IDLE, 0, OP_RST, 0, "R6 underflow flag");
      // R7: clear leaves not-empty untouched
      step(OP_TX, 32'h7777_0000, OP_IDLE, 0, "R7 refill");
      step(OP_IDLE, 0, OP_WST, 0, "R7 clear B");
      step(OP_IDLE, 0, OP_RST, 0, "R7 not-empty kept");
      step(OP_RX, 0, OP_IDLE, 0, "R6 A empty read");
      step(OP_TX, 32'h0, OP_RST, 0, "R7 B flags stay clear");
      // mixed pseudo-random traffic
      for (int i = 0; i < 600; i++) begin
         int oa = int'($urandom_range(0, 5));
         int ob = int'($urandom_range(0, 5));
         step(oa, $urandom, ob, $urandom, "R1 random traffic");
      end
      // R10: reset with data pending
      for (int i = 0; i < 4; i++) step(OP_TX, i, OP_TX, i, "R10 preload");
      do_reset();
      step(OP_RST, 0, OP_RST, 0, "R10 status after reset");
      step(OP_RX, 0, OP_RX, 0, "R10 empty after reset");
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule